// File: doc/BRIEF.md
# Alignment FIFO Fill-Window Monitor

This block watches the fill levels of a group of receive alignment FIFOs against one shared allowed window. The window has a lower bound and an upper bound, each held in a 5-bit programmable register. Every cycle, each channel's level is compared with both bounds. When a channel leaves the window, the block issues a one-cycle event for that channel and sets a sticky alarm flag for it.

Software clears flags by writing ones to a clear mask. A per-channel enable mask selects which flags drive the single aggregate interrupt. Threshold writes outside the legal range of a bound are clamped to the nearest legal value, so software can never program an illegal window. The FIFOs and any bus decoding are outside the block. Levels arrive as a packed input vector, with channel `c` at bits `[c*LVL_W +: LVL_W]`.

Top module: `afifo_window_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, the registers load as follows after that edge: lower bound 2, upper bound 15, `evt_o`, `flag_o` and `irq_o` all zero.
- R2: A write with `thr_min_we` high loads the lower bound with `thr_wdata` clamped to the range 1 to 23. The value shows on `thr_min_o` after the edge.
- R3: A write with `thr_max_we` high loads the upper bound with `thr_wdata` clamped to the range 0 to 22. The value shows on `thr_max_o` after the edge.
- R4: A channel is in violation when its level is strictly less than the lower bound or strictly greater than the upper bound. A level equal to either bound is in range.
- R5: When a channel's level sampled at an edge is in violation, and the level sampled at the previous edge was not, `evt_o` for that channel is high for the one cycle after that edge. The violation history is zero out of reset.
- R6: A channel that stays in violation on consecutive edges raises no further event until it has first been seen in range.
- R7: A channel's bit in `flag_o` goes high in the same cycle as its event, and stays high until it is cleared.
- R8: At an edge with `clr_we` high, each flag whose `clr_mask` bit is 1 clears. If an event for that channel occurs at the same edge, the flag stays set.
- R9: After each edge, `irq_o` is the OR over channels of the new flag value ANDed with the `irq_en` bit sampled at that edge.
- R10: All channels are compared against the same bounds. A bound written at one edge applies to every channel's compare from the next edge onward. A lower bound above the upper bound makes every level a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_i | input | NUM_CH*LVL_W | Packed per-channel FIFO fill levels |
| thr_min_we | input | 1 | Write strobe for the lower bound |
| thr_max_we | input | 1 | Write strobe for the upper bound |
| thr_wdata | input | THR_W | Threshold write value |
| clr_we | input | 1 | Clear strobe for sticky flags |
| clr_mask | input | NUM_CH | Write-one-to-clear flag mask |
| irq_en | input | NUM_CH | Per-channel interrupt enable |
| thr_min_o | output | THR_W | Current lower bound |
| thr_max_o | output | THR_W | Current upper bound |
| evt_o | output | NUM_CH | One-cycle violation event per channel |
| flag_o | output | NUM_CH | Sticky violation flag per channel |
| irq_o | output | 1 | Aggregate masked interrupt |

## Verification
The bench builds the block with its defaults: four channels, and 5-bit levels and bounds. With 5-bit levels the stimulus can reach every code from 0 to 31. That covers values at each bound, one step beyond each bound, and the codes above 23 that the clamp must fold back. Four channels are enough to drive distinct levels in parallel, so one cycle can show a set, a clear, a clear that loses to a set, and an untouched flag. The stimulus also covers an inverted window and a full sweep of levels against a narrow window.

// File: rtl/afw_pkg.sv
package afw_pkg;
  typedef struct packed {
    logic below;
    logic above;
  } afw_cmp_t;

  function automatic int afw_clamp(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/afw_thr_regs.sv
module afw_thr_regs #(
  parameter int THR_W   = 5,
  parameter int MIN_RST = 2,
  parameter int MAX_RST = 15,
  parameter int MIN_LO  = 1,
  parameter int MIN_HI  = 23,
  parameter int MAX_LO  = 0,
  parameter int MAX_HI  = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             min_we,
  input  logic             max_we,
  input  logic [THR_W-1:0] wdata,
  output logic [THR_W-1:0] thr_min,
  output logic [THR_W-1:0] thr_max
);
  import afw_pkg::*;

  localparam logic [THR_W-1:0] MIN_RST_V = THR_W'(MIN_RST);
  localparam logic [THR_W-1:0] MAX_RST_V = THR_W'(MAX_RST);

  logic [THR_W-1:0] min_cl, max_cl;

  always_comb begin
    min_cl = THR_W'(afw_clamp(int'(wdata), MIN_LO, MIN_HI));
    max_cl = THR_W'(afw_clamp(int'(wdata), MAX_LO, MAX_HI));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_min <= MIN_RST_V;
      thr_max <= MAX_RST_V;
    end else begin
      if (min_we) thr_min <= min_cl;
      if (max_we) thr_max <= max_cl;
    end
  end
endmodule

// File: rtl/afw_chan_cmp.sv
module afw_chan_cmp #(
  parameter int LVL_W = 5,
  parameter int THR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] lvl,
  input  logic [THR_W-1:0] thr_min,
  input  logic [THR_W-1:0] thr_max,
  output logic             evt_next,
  output logic             evt_q
);
  import afw_pkg::*;

  afw_cmp_t cmp;
  logic     viol;
  logic     viol_q;

  always_comb begin
    cmp.below = int'(lvl) < int'(thr_min);
    cmp.above = int'(lvl) > int'(thr_max);
    viol      = cmp.below | cmp.above;
    evt_next  = viol & ~viol_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      viol_q <= viol;
      evt_q  <= evt_next;
    end
  end
endmodule

// File: rtl/afw_flag_bank.sv
module afw_flag_bank #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] set_i,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_mask,
  input  logic [NUM_CH-1:0] irq_en,
  output logic [NUM_CH-1:0] flag_q,
  output logic              irq_q
);
  logic [NUM_CH-1:0] clr_eff;
  logic [NUM_CH-1:0] flag_d;

  always_comb begin
    clr_eff = clr_we ? clr_mask : '0;
    flag_d  = (flag_q & ~clr_eff) | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= |(flag_d & irq_en);
    end
  end
endmodule

// File: rtl/afifo_window_monitor.sv
module afifo_window_monitor #(
  parameter int NUM_CH  = 4,
  parameter int LVL_W   = 5,
  parameter int THR_W   = 5,
  parameter int MIN_RST = 2,
  parameter int MAX_RST = 15,
  parameter int MIN_LO  = 1,
  parameter int MIN_HI  = 23,
  parameter int MAX_LO  = 0,
  parameter int MAX_HI  = 22
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH*LVL_W-1:0] lvl_i,
  input  logic                    thr_min_we,
  input  logic                    thr_max_we,
  input  logic [THR_W-1:0]        thr_wdata,
  input  logic                    clr_we,
  input  logic [NUM_CH-1:0]       clr_mask,
  input  logic [NUM_CH-1:0]       irq_en,
  output logic [THR_W-1:0]        thr_min_o,
  output logic [THR_W-1:0]        thr_max_o,
  output logic [NUM_CH-1:0]       evt_o,
  output logic [NUM_CH-1:0]       flag_o,
  output logic                    irq_o
);
  logic [NUM_CH-1:0] evt_next;

  afw_thr_regs #(
    .THR_W(THR_W), .MIN_RST(MIN_RST), .MAX_RST(MAX_RST),
    .MIN_LO(MIN_LO), .MIN_HI(MIN_HI), .MAX_LO(MAX_LO), .MAX_HI(MAX_HI)
  ) u_thr (
    .clk(clk), .rst(rst), .min_we(thr_min_we), .max_we(thr_max_we),
    .wdata(thr_wdata), .thr_min(thr_min_o), .thr_max(thr_max_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    afw_chan_cmp #(.LVL_W(LVL_W), .THR_W(THR_W)) u_cmp (
      .clk(clk), .rst(rst),
      .lvl(lvl_i[c*LVL_W +: LVL_W]),
      .thr_min(thr_min_o), .thr_max(thr_max_o),
      .evt_next(evt_next[c]), .evt_q(evt_o[c])
    );
  end

  afw_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
    .clk(clk), .rst(rst), .set_i(evt_next),
    .clr_we(clr_we), .clr_mask(clr_mask), .irq_en(irq_en),
    .flag_q(flag_o), .irq_q(irq_o)
  );
endmodule

// File: rtl/afw_mon_checker.sv
module afw_mon_checker #(
  parameter int NUM_CH  = 4,
  parameter int THR_W   = 5,
  parameter int MIN_RST = 2,
  parameter int MAX_RST = 15,
  parameter int MIN_LO  = 1,
  parameter int MIN_HI  = 23,
  parameter int MAX_LO  = 0,
  parameter int MAX_HI  = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              clr_we,
  input logic [NUM_CH-1:0] clr_mask,
  input logic [NUM_CH-1:0] irq_en,
  input logic [THR_W-1:0]  thr_min_o,
  input logic [THR_W-1:0]  thr_max_o,
  input logic [NUM_CH-1:0] evt_o,
  input logic [NUM_CH-1:0] flag_o,
  input logic              irq_o
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (thr_min_o == THR_W'(MIN_RST) && thr_max_o == THR_W'(MAX_RST)
             && evt_o == '0 && flag_o == '0 && !irq_o));

  a_r2_min_legal: assert property (@(posedge clk) disable iff (rst)
    int'(thr_min_o) >= MIN_LO && int'(thr_min_o) <= MIN_HI);

  a_r3_max_legal: assert property (@(posedge clk) disable iff (rst)
    int'(thr_max_o) >= MAX_LO && int'(thr_max_o) <= MAX_HI);

  a_r9_irq_mask: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_o == |(flag_o & $past(irq_en))));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
      evt_o[c] |=> !evt_o[c]);

    a_r7_event_flags: assert property (@(posedge clk) disable iff (rst)
      evt_o[c] |-> flag_o[c]);

    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
      (flag_o[c] && !(clr_we && clr_mask[c])) |=> flag_o[c]);
  end
endmodule

bind afifo_window_monitor afw_mon_checker #(
  .NUM_CH(NUM_CH), .THR_W(THR_W), .MIN_RST(MIN_RST), .MAX_RST(MAX_RST),
  .MIN_LO(MIN_LO), .MIN_HI(MIN_HI), .MAX_LO(MAX_LO), .MAX_HI(MAX_HI)
) u_chk (
  .clk(clk), .rst(rst), .clr_we(clr_we), .clr_mask(clr_mask), .irq_en(irq_en),
  .thr_min_o(thr_min_o), .thr_max_o(thr_max_o), .evt_o(evt_o),
  .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/afifo_window_monitor_bench.sv
module afifo_window_monitor_bench;
  localparam int NCH = 4;
  localparam int LW  = 5;
  localparam int TW  = 5;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NCH*LW-1:0] lvl_i = '0;
  logic            thr_min_we = 1'b0;
  logic            thr_max_we = 1'b0;
  logic [TW-1:0]   thr_wdata = '0;
  logic            clr_we = 1'b0;
  logic [NCH-1:0]  clr_mask = '0;
  logic [NCH-1:0]  irq_en = '0;
  logic [TW-1:0]   thr_min_o, thr_max_o;
  logic [NCH-1:0]  evt_o, flag_o;
  logic            irq_o;

  afifo_window_monitor u_afifo_window_monitor (
    .clk(clk), .rst(rst), .lvl_i(lvl_i), .thr_min_we(thr_min_we),
    .thr_max_we(thr_max_we), .thr_wdata(thr_wdata), .clr_we(clr_we),
    .clr_mask(clr_mask), .irq_en(irq_en), .thr_min_o(thr_min_o),
    .thr_max_o(thr_max_o), .evt_o(evt_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  // behavioural reference
  int  m_min, m_max;
  bit  m_prev [NCH];
  bit  m_flag [NCH];
  bit  m_evt  [NCH];
  bit  m_irq;
  bit  started = 0;
  int  n_vec = 0, n_bad = 0;
  string phase = "R1";

  function automatic int clampv(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_min = 2; m_max = 15; m_irq = 0;
      for (int c = 0; c < NCH; c++) begin
        m_prev[c] = 0; m_flag[c] = 0; m_evt[c] = 0;
      end
    end else begin
      m_irq = 0;
      for (int c = 0; c < NCH; c++) begin
        int  lv;
        bit  v;
        lv = int'(lvl_i[c*LW +: LW]);
        v  = (lv < m_min) || (lv > m_max);
        m_evt[c]  = v && !m_prev[c];
        m_prev[c] = v;
        if (clr_we && clr_mask[c]) m_flag[c] = 0;
        if (m_evt[c]) m_flag[c] = 1;
        if (m_flag[c] && irq_en[c]) m_irq = 1;
      end
      if (thr_min_we) m_min = clampv(int'(thr_wdata), 1, 23);
      if (thr_max_we) m_max = clampv(int'(thr_wdata), 0, 22);
    end
  end

  always @(negedge clk) begin
    if (started) begin
      n_vec++;
      if (int'(thr_min_o) != m_min) begin
        n_bad++;
        $display("FAIL R2 [%s] thr_min_o got %0d exp %0d", phase, thr_min_o, m_min);
      end
      if (int'(thr_max_o) != m_max) begin
        n_bad++;
        $display("FAIL R3 [%s] thr_max_o got %0d exp %0d", phase, thr_max_o, m_max);
      end
      for (int c = 0; c < NCH; c++) begin
        if (evt_o[c] != m_evt[c]) begin
          n_bad++;
          $display("FAIL R5 [%s] evt_o[%0d] got %0b exp %0b", phase, c, evt_o[c], m_evt[c]);
        end
        if (flag_o[c] != m_flag[c]) begin
          n_bad++;
          $display("FAIL R7 [%s] flag_o[%0d] got %0b exp %0b", phase, c, flag_o[c], m_flag[c]);
        end
      end
      if (irq_o != m_irq) begin
        n_bad++;
        $display("FAIL R9 [%s] irq_o got %0b exp %0b", phase, irq_o, m_irq);
      end
    end
  end

  task automatic set_lv(input int a, input int b, input int c, input int d);
    lvl_i = {LW'(d), LW'(c), LW'(b), LW'(a)};
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_thr(input bit is_min, input int v);
    thr_wdata = TW'(v);
    if (is_min) thr_min_we = 1; else thr_max_we = 1;
    tick(1);
    thr_min_we = 0; thr_max_we = 0;
  endtask

  bit done = 0;

  initial begin
    phase = "R1";
    set_lv(8, 8, 8, 8);
    tick(3);
    rst = 0;
    irq_en = 4'b1111;
    tick(2);
    phase = "R4";                    // equal to bounds stays in range
    set_lv(2, 15, 8, 8); tick(2);
    set_lv(1, 15, 8, 8); tick(1);    // ch0 below
    phase = "R6";
    tick(3);                         // stays out: no retrigger
    set_lv(1, 16, 8, 8); tick(2);    // ch1 above
    set_lv(5, 5, 8, 8);  tick(2);
    set_lv(0, 5, 31, 8); tick(2);    // re-entry events
    phase = "R8";
    irq_en = 4'b0100;
    clr_we = 1; clr_mask = 4'b0011; tick(1);
    clr_we = 0; clr_mask = '0; tick(1);
    set_lv(5, 5, 8, 8); tick(1);
    set_lv(0, 5, 8, 8);              // ch0 event with clear same edge
    clr_we = 1; clr_mask = 4'b1111; tick(1);
    clr_we = 0; clr_mask = '0; tick(2);
    irq_en = 4'b0000; tick(2);
    irq_en = 4'b0001; tick(2);
    phase = "R2";
    wr_thr(1, 0);  tick(1);
    wr_thr(1, 31); tick(1);
    wr_thr(1, 23); tick(1);
    phase = "R3";
    wr_thr(0, 31); tick(1);
    wr_thr(0, 0);  tick(1);
    wr_thr(0, 22); tick(1);
    phase = "R10";                   // min 23 > max 22: all violate
    clr_we = 1; clr_mask = 4'b1111; tick(1);
    clr_we = 0; clr_mask = '0;
    set_lv(22, 23, 0, 31); tick(3);
    wr_thr(1, 5); wr_thr(0, 10);
    irq_en = 4'b1010;
    for (int s = 0; s < 32; s++) begin
      set_lv(s, (s + 7) % 32, (s + 13) % 32, 31 - s);
      if (s % 6 == 5) begin clr_we = 1; clr_mask = 4'(s); end
      tick(1);
      clr_we = 0; clr_mask = '0;
    end
    phase = "R1";
    rst = 1; tick(2);
    rst = 0; set_lv(8, 8, 8, 8); tick(3);
    done = 1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
    end
    tick(1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule